// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block collects single-cycle event pulses from a MAC datapath into a 32-bit sticky event register. Software clears the events it has handled by writing ones to that register. A 32-bit enable mask decides which events may raise an interrupt.

Thirteen event bits, from bit 31 down to bit 19, each drive a dedicated interrupt output line. The mapping from bits to lines follows a fixed order that is not sequential. The other event bits can still be set and read, but no line follows them.

Each line is registered, so it shows the masked state of its bit one cycle later. A simple register port at two word offsets gives read and write access to the event register and the mask.

Top module: `evt_irq_fanout`

## Requirements
- R1: After synchronous active-high reset, the event register, the mask register and all 13 output lines are 0.
- R2: A pulse on bit k of `evt_set_i` sets event bit k on the next clock edge. The bit stays set until software clears it.
- R3: A write to offset 0x004 clears every event bit that is 1 in the written data. Bits written as 0 keep their value.
- R4: When a set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x008 replaces the whole mask register.
- R6: A read returns the event register at offset 0x004 and the mask at offset 0x008, combinationally. Any other offset reads 0. A write to any other offset changes nothing.
- R7: Output line n is high one cycle after both its event bit and its mask bit are 1. The lines map to event bits in this order: line 0 = bit 27 (tx frame), 1 = 26 (tx buffer), 2 = 19 (underrun), 3 = 20 (retry limit), 4 = 25 (rx frame), 5 = 24 (rx buffer), 6 = 23 (management), 7 = 21 (late collision), 8 = 31 (heartbeat), 9 = 28 (graceful stop), 10 = 22 (bus error), 11 = 29 (babbling tx), 12 = 30 (babbling rx).
- R8: Event bits 18 down to 0 set and clear like the others, but they drive no output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 32 | Event set pulses, one bit per event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the offset on reg_addr_i |
| irq_o | output | 13 | Dedicated interrupt lines |

## Verification
Two operations can hit the same event bit in one cycle: a hardware set pulse and a software write-one-to-clear. The bench drives both together on the same bits and expects the bit to remain set.

It also overlaps a set pulse on a bit whose mask is changing in that same cycle. It then checks that the line follows the new combination one cycle later.

A behavioural reference model steps alongside the design every cycle. It is compared on both read offsets and on all 13 lines.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned N_LINES  = 13;
  localparam logic [ADDR_W-1:0] OFF_EVENT = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 10'h008;

  // Event bit feeding each output line, line 0 first.
  function automatic int unsigned line_src(input int unsigned n);
    case (n)
      0:  return 27;
      1:  return 26;
      2:  return 19;
      3:  return 20;
      4:  return 25;
      5:  return 24;
      6:  return 23;
      7:  return 21;
      8:  return 31;
      9:  return 28;
      10: return 22;
      11: return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [W-1:0]  evt_set_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  event_q_o,
  output logic [W-1:0]  mask_q_o
);
  logic          hit_evt, hit_msk;
  logic [W-1:0]  clr_vec;

  assign hit_evt = reg_wr_i && (reg_addr_i == AW'(OFF_EVENT));
  assign hit_msk = reg_wr_i && (reg_addr_i == AW'(OFF_MASK));
  assign clr_vec = hit_evt ? reg_wdata_i : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      event_q_o <= '0;
      mask_q_o  <= '0;
    end else begin
      // set has priority over clear
      event_q_o <= (event_q_o & ~clr_vec) | evt_set_i;
      if (hit_msk) mask_q_o <= reg_wdata_i;
    end
  end
endmodule

// File: rtl/evt_irq_lines.sv
module evt_irq_lines
  import evt_irq_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned L = N_LINES
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] event_i,
  input  logic [W-1:0] mask_i,
  output logic [L-1:0] irq_o
);
  logic [W-1:0] active;
  assign active = event_i & mask_i;

  for (genvar n = 0; n < L; n++) begin : g_line
    localparam int unsigned SRC = line_src(n);
    always_ff @(posedge clk_i) begin
      if (rst_i) irq_o[n] <= 1'b0;
      else       irq_o[n] <= active[SRC];
    end
  end
endmodule

// File: rtl/evt_irq_fanout.sv
module evt_irq_fanout
  import evt_irq_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned L  = N_LINES
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [W-1:0]  evt_set_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic [L-1:0]  irq_o
);
  logic [W-1:0] event_q, mask_q;

  evt_irq_regs #(.W(W), .AW(AW)) u_regs (
    .clk_i, .rst_i, .evt_set_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .event_q_o(event_q), .mask_q_o(mask_q)
  );

  evt_irq_lines #(.W(W), .L(L)) u_lines (
    .clk_i, .rst_i, .event_i(event_q), .mask_i(mask_q), .irq_o
  );

  always_comb begin
    if (reg_addr_i == AW'(OFF_EVENT))     reg_rdata_o = event_q;
    else if (reg_addr_i == AW'(OFF_MASK)) reg_rdata_o = mask_q;
    else                                  reg_rdata_o = '0;
  end
endmodule

// File: rtl/evt_irq_fanout_chk.sv
module evt_irq_fanout_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned L  = N_LINES
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [W-1:0]  evt_set_i,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [W-1:0]  reg_wdata_i,
  input logic [W-1:0]  event_q,
  input logic [W-1:0]  mask_q,
  input logic [L-1:0]  irq_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (event_q == '0 && mask_q == '0 && irq_o == '0));

  p_set_sticks_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((event_q & $past(evt_set_i)) == $past(evt_set_i)));

  p_set_beats_clear_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (reg_wr_i && reg_addr_i == AW'(OFF_EVENT) && (evt_set_i & reg_wdata_i) != '0)
    |=> ((event_q & $past(evt_set_i & reg_wdata_i)) == $past(evt_set_i & reg_wdata_i)));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(reg_wr_i && reg_addr_i == AW'(OFF_MASK)) |=> $stable(mask_q));

  p_no_spurious_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((event_q & ~$past(event_q) & ~$past(evt_set_i)) == '0));

  p_line_count_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($countones(irq_o) <= $countones($past(event_q & mask_q))));
endmodule

bind evt_irq_fanout evt_irq_fanout_chk #(.W(W), .AW(AW), .L(L)) u_chk (
  .clk_i, .rst_i, .evt_set_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
  .event_q, .mask_q, .irq_o
);

// File: tb/evt_irq_fanout_tb_top.sv
module evt_irq_fanout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_i;
  logic [31:0] evt_set_i;
  logic        reg_wr_i;
  logic [9:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [12:0] irq_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [31:0] m_evt, m_msk;
  logic [12:0] m_irq;
  int map [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_fanout dut_i (
    .clk_i(clk), .rst_i, .evt_set_i, .reg_wr_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  always @(posedge clk) begin
    logic [31:0] act;
    act = m_evt & m_msk;
    if (rst_i) begin
      m_evt <= '0; m_msk <= '0; m_irq <= '0;
    end else begin
      for (int n = 0; n < 13; n++) m_irq[n] <= act[map[n]];
      m_evt <= (m_evt & ~((reg_wr_i && reg_addr_i == 10'h004) ? reg_wdata_i : 32'h0)) | evt_set_i;
      if (reg_wr_i && reg_addr_i == 10'h008) m_msk <= reg_wdata_i;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle compare on the falling edge (lines vs model)
  always @(negedge clk) begin
    if (!rst_i && m_irq !== 13'bx) chk("R7 lines", {19'h0, irq_o}, {19'h0, m_irq});
  end

  task automatic step(input logic [31:0] set, input logic wr,
                      input logic [9:0] a, input logic [31:0] d);
    evt_set_i = set; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    evt_set_i = '0; reg_wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp);
    reg_addr_i = a; #1;
    chk(req, reg_rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_i = 1'b1; evt_set_i = '0; reg_wr_i = 0; reg_addr_i = 10'h004; reg_wdata_i = '0;
    repeat (3) @(posedge clk); #1;
    rst_i = 1'b0;
    rd("R1 event", 10'h004, 32'h0);
    rd("R1 mask", 10'h008, 32'h0);
    chk("R1 irq", {19'h0, irq_o}, 32'h0);

    // R2: set pulses stick
    step(32'h0800_0001, 0, 10'h004, 0);
    step(0, 0, 10'h004, 0);
    rd("R2 sticky", 10'h004, 32'h0800_0001);
    // R8: low bits settable but no line
    rd("R8 low bit", 10'h004, m_evt);
    // R5: mask write
    step(0, 1, 10'h008, 32'hFFFF_FFFF);
    rd("R5 mask", 10'h008, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk("R7 tx frame line0", {19'h0, irq_o}, 32'h1);
    chk("R8 no line from bit0", {19'h0, irq_o}, 32'h1);

    // walk each line
    step(0, 1, 10'h004, 32'hFFFF_FFFF);
    for (int n = 0; n < 13; n++) begin
      step(32'h1 << map[n], 0, 10'h004, 0);
      @(posedge clk); #1;
      chk("R7 mapping", {19'h0, irq_o}, 32'h1 << n);
      step(0, 1, 10'h004, 32'h1 << map[n]);
    end
    @(posedge clk); #1;
    chk("R3 cleared lines", {19'h0, irq_o}, 32'h0);

    // R3 partial clear
    step(32'hF00F_0000, 0, 10'h004, 0);
    step(0, 1, 10'h004, 32'h3000_0000);
    rd("R3 partial clear", 10'h004, 32'hC00F_0000);
    // R4 set and clear same bit
    step(32'h0200_0000, 1, 10'h004, 32'hC200_0000);
    rd("R4 set wins", 10'h004, 32'h020F_0000);
    // R6 other offsets
    step(32'h0, 1, 10'h00C, 32'hFFFF_FFFF);
    rd("R6 bad read", 10'h00C, 32'h0);
    rd("R6 bad write event", 10'h004, 32'h020F_0000);
    rd("R6 bad write mask", 10'h008, 32'hFFFF_FFFF);
    // mask change coinciding with set
    step(32'h8000_0000, 1, 10'h008, 32'h0200_0000);
    @(posedge clk); #1;
    chk("R7 masked", {19'h0, irq_o}, 32'h1 << 4);
    rd("R5 mask replaced", 10'h008, 32'h0200_0000);
    // model compare on registers
    rd("R6 model evt", 10'h004, m_evt);
    rd("R6 model msk", 10'h008, m_msk);

    // reset mid-run
    rst_i = 1'b1; @(posedge clk); #1; rst_i = 1'b0;
    rd("R1 event after rst", 10'h004, 32'h0);
    rd("R1 mask after rst", 10'h008, 32'h0);
    chk("R1 irq after rst", {19'h0, irq_o}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule